// File: doc/BRIEF.md
# ATA PIO Cycle Timing Controller

This block runs one programmed-I/O transfer on an ATA drive interface. Four phase lengths come in as clock counts: address setup, strobe width, write data hold and end-of-cycle recovery. A one-clock start pulse launches the transfer, and a direction bit sampled with it picks a read or a write. The block then steps through the phases. It drives the read or write strobe, the host data-driver enable and a read-data capture pulse. When the whole cycle, recovery included, is over, it raises a one-clock completion pulse.

A phase programmed with value N lasts N+1 clocks. At 100 MHz the mode-0 settings of 6, 28, 2 and 23 therefore give 70 ns setup, 290 ns strobe, 30 ns hold and 240 ns recovery. A read totals 600 ns. When the device-ready input is enabled, the device can stretch the strobe by holding ready low. That input must already be synchronised. Address decode, chip selects, data registers and the bus-side handshake belong to the surrounding logic.

Top module: `ata_pio_timer`

## Requirements
- R1: After either reset (asynchronous `arst_n` low or synchronous `srst` high at a clock edge), `rd_strb`, `wr_strb`, `oe`, `rd_latch` and `done` are all 0 and the block is idle.
- R2: When `go` is 1 at clock edge E0 in idle, the selected strobe is first high in the cycle that starts t_setup+1 edges after E0, i.e. setup lasts t_setup+1 clocks with both strobes low.
- R3: With ready not holding it, the strobe stays high for exactly t_active+1 clocks.
- R4: `wr`=1 sampled with `go` selects a write (only `wr_strb` rises); `wr`=0 selects a read (only `rd_strb` rises). Both strobes are never high together.
- R5: On a write, `oe` is high for t_setup+t_active+t_hold+3 consecutive clocks starting the cycle after E0, covering setup, strobe and hold. On a read, `oe` stays 0.
- R6: On a read, `rd_latch` is high for exactly one clock: the first clock after `rd_strb` falls. On a write it stays 0.
- R7: `done` is high for exactly one clock. It appears t_recover+1 clocks after the last strobe clock (read) or the last hold clock (write). Afterwards the block is idle.
- R8: With `rdy_en`=1, if `rdy_in` is 0 at the edge where the strobe count has expired, the strobe stays high. It falls at the first edge that samples `rdy_in`=1, and the cycle then proceeds normally.
- R9: With `rdy_en`=0, `rdy_in` has no effect on any output timing.
- R10: A `go` pulse during a cycle in progress is ignored. The cycle keeps its timing and no second cycle follows.
- R11: `srst` in the middle of a cycle aborts it. All outputs are 0 from the next clock, and no strobe follows until a new `go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous reset, active low |
| srst | input | 1 | Synchronous reset, active high |
| rdy_en | input | 1 | Honour the device-ready input |
| t_setup | input | CW | Address setup length (clocks minus one) |
| t_active | input | CW | Strobe width (clocks minus one) |
| t_hold | input | CW | Write data hold length (clocks minus one) |
| t_recover | input | CW | End-of-cycle recovery length (clocks minus one) |
| go | input | 1 | One-clock start pulse |
| wr | input | 1 | Direction, 1 = write to device, 0 = read |
| rdy_in | input | 1 | Synchronised device-ready, high = ready |
| rd_strb | output | 1 | Read strobe, active high |
| wr_strb | output | 1 | Write strobe, active high |
| oe | output | 1 | Host data-driver enable (writes) |
| rd_latch | output | 1 | One-clock pulse to capture read data |
| done | output | 1 | One-clock end-of-cycle pulse |

## Verification
The bench goes after off-by-one phase lengths. It checks all-zero programming, where a design that treats zero as "skip" would merge phases. It checks mode-0 values, where a miscounted phase breaks the 60-clock read total. A ready signal held low past the count must stretch the strobe by exactly the extra clocks. The same low level with the enable clear must change nothing, which catches a design that ignores the enable. A second start pulse during setup would restart or double the cycle in a flawed design. A mid-strobe synchronous reset would leave a strobe or the driver enable hanging.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_SETUP  = 3'd1,
      PH_ACTIVE = 3'd2,
      PH_HOLD   = 3'd3,
      PH_RECOV  = 3'd4,
      PH_DONE   = 3'd5
   } pio_phase_e;
endpackage

// File: rtl/ata_pio_cnt.sv
module ata_pio_cnt #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          arst_n,
   input  logic          srst,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);
   logic [CW-1:0] q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         q <= '0;
      end else if (srst) begin
         q <= '0;
      end else if (load) begin
         q <= load_val;
      end else if (q != '0) begin
         q <= q - 1'b1;
      end
   end

   assign zero = (q == '0);
endmodule

// File: rtl/ata_pio_rdy_gate.sv
module ata_pio_rdy_gate #(
   parameter bit HAS_RDY = 1'b1
) (
   input  logic rdy_en,
   input  logic rdy_in,
   output logic ready_ok
);
   if (HAS_RDY) begin : g_rdy
      assign ready_ok = !rdy_en || rdy_in;
   end else begin : g_no_rdy
      logic unused_rdy;
      assign unused_rdy = rdy_en ^ rdy_in;
      assign ready_ok   = 1'b1;
   end
endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
   import ata_pio_pkg::*;
(
   input  logic       clk,
   input  logic       arst_n,
   input  logic       srst,
   input  logic       go,
   input  logic       wr,
   input  logic       cnt_zero,
   input  logic       ready_ok,
   output pio_phase_e phase,
   output logic       wr_q,
   output logic       latch_q,
   output logic       load,
   output pio_phase_e load_phase
);
   pio_phase_e phase_nxt;
   logic       wr_nxt;
   logic       latch_nxt;

   always_comb begin
      phase_nxt  = phase;
      wr_nxt     = wr_q;
      latch_nxt  = 1'b0;
      load       = 1'b0;
      load_phase = PH_IDLE;
      unique case (phase)
         PH_IDLE: begin
            if (go) begin
               phase_nxt  = PH_SETUP;
               wr_nxt     = wr;
               load       = 1'b1;
               load_phase = PH_SETUP;
            end
         end
         PH_SETUP: begin
            if (cnt_zero) begin
               phase_nxt  = PH_ACTIVE;
               load       = 1'b1;
               load_phase = PH_ACTIVE;
            end
         end
         PH_ACTIVE: begin
            if (cnt_zero && ready_ok) begin
               load = 1'b1;
               if (wr_q) begin
                  phase_nxt  = PH_HOLD;
                  load_phase = PH_HOLD;
               end else begin
                  phase_nxt  = PH_RECOV;
                  load_phase = PH_RECOV;
                  latch_nxt  = 1'b1;
               end
            end
         end
         PH_HOLD: begin
            if (cnt_zero) begin
               phase_nxt  = PH_RECOV;
               load       = 1'b1;
               load_phase = PH_RECOV;
            end
         end
         PH_RECOV: begin
            if (cnt_zero) begin
               phase_nxt = PH_DONE;
            end
         end
         PH_DONE: begin
            phase_nxt = PH_IDLE;
         end
         default: begin
            phase_nxt = PH_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         phase   <= PH_IDLE;
         wr_q    <= 1'b0;
         latch_q <= 1'b0;
      end else if (srst) begin
         phase   <= PH_IDLE;
         wr_q    <= 1'b0;
         latch_q <= 1'b0;
      end else begin
         phase   <= phase_nxt;
         wr_q    <= wr_nxt;
         latch_q <= latch_nxt;
      end
   end
endmodule

// File: rtl/ata_pio_timer.sv
module ata_pio_timer
   import ata_pio_pkg::*;
#(
   parameter int CW      = 8,
   parameter bit HAS_RDY = 1'b1
) (
   input  logic          clk,
   input  logic          arst_n,
   input  logic          srst,
   input  logic          rdy_en,
   input  logic [CW-1:0] t_setup,
   input  logic [CW-1:0] t_active,
   input  logic [CW-1:0] t_hold,
   input  logic [CW-1:0] t_recover,
   input  logic          go,
   input  logic          wr,
   input  logic          rdy_in,
   output logic          rd_strb,
   output logic          wr_strb,
   output logic          oe,
   output logic          rd_latch,
   output logic          done
);
   localparam int CW_MIN = 2;
   localparam int CW_MAX = 16;

   if (CW < CW_MIN || CW > CW_MAX) begin : g_bad_cw
      $error("ata_pio_timer: CW must lie between 2 and 16");
   end

   pio_phase_e    phase;
   pio_phase_e    load_phase;
   logic          wr_q;
   logic          latch_q;
   logic          load;
   logic          cnt_zero;
   logic          ready_ok;
   logic [CW-1:0] load_val;

   always_comb begin
      unique case (load_phase)
         PH_SETUP:  load_val = t_setup;
         PH_ACTIVE: load_val = t_active;
         PH_HOLD:   load_val = t_hold;
         PH_RECOV:  load_val = t_recover;
         default:   load_val = '0;
      endcase
   end

   ata_pio_rdy_gate #(.HAS_RDY(HAS_RDY)) u_rdy (
      .rdy_en   (rdy_en),
      .rdy_in   (rdy_in),
      .ready_ok (ready_ok)
   );

   ata_pio_cnt #(.CW(CW)) u_cnt (
      .clk      (clk),
      .arst_n   (arst_n),
      .srst     (srst),
      .load     (load),
      .load_val (load_val),
      .zero     (cnt_zero)
   );

   ata_pio_seq u_seq (
      .clk        (clk),
      .arst_n     (arst_n),
      .srst       (srst),
      .go         (go),
      .wr         (wr),
      .cnt_zero   (cnt_zero),
      .ready_ok   (ready_ok),
      .phase      (phase),
      .wr_q       (wr_q),
      .latch_q    (latch_q),
      .load       (load),
      .load_phase (load_phase)
   );

   assign rd_strb  = (phase == PH_ACTIVE) && !wr_q;
   assign wr_strb  = (phase == PH_ACTIVE) &&  wr_q;
   assign oe       = wr_q && ((phase == PH_SETUP) || (phase == PH_ACTIVE) ||
                              (phase == PH_HOLD));
   assign rd_latch = latch_q;
   assign done     = (phase == PH_DONE);
endmodule

// File: rtl/ata_pio_timer_chk.sv
module ata_pio_timer_chk (
   input logic clk,
   input logic arst_n,
   input logic srst,
   input logic rdy_en,
   input logic rdy_in,
   input logic rd_strb,
   input logic wr_strb,
   input logic oe,
   input logic rd_latch,
   input logic done
);
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!arst_n)
      !(rd_strb && wr_strb)); // R4

   AST_READ_NO_OE: assert property (@(posedge clk) disable iff (!arst_n)
      rd_strb |-> !oe); // R5

   AST_WRITE_HAS_OE: assert property (@(posedge clk) disable iff (!arst_n)
      wr_strb |-> oe); // R5

   AST_LATCH_AFTER_READ: assert property (@(posedge clk) disable iff (!arst_n || srst)
      rd_latch |-> (!rd_strb && $past(rd_strb))); // R6

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!arst_n)
      done |=> !done); // R7

   AST_RDY_STRETCH_RD: assert property (@(posedge clk) disable iff (!arst_n || srst)
      (rdy_en && !rdy_in && rd_strb) |=> rd_strb); // R8

   AST_RDY_STRETCH_WR: assert property (@(posedge clk) disable iff (!arst_n || srst)
      (rdy_en && !rdy_in && wr_strb) |=> wr_strb); // R8

   AST_SRST_IDLE: assert property (@(posedge clk) disable iff (!arst_n)
      srst |=> (!rd_strb && !wr_strb && !oe && !rd_latch && !done)); // R11
endmodule

bind ata_pio_timer ata_pio_timer_chk u_chk (
   .clk      (clk),
   .arst_n   (arst_n),
   .srst     (srst),
   .rdy_en   (rdy_en),
   .rdy_in   (rdy_in),
   .rd_strb  (rd_strb),
   .wr_strb  (wr_strb),
   .oe       (oe),
   .rd_latch (rd_latch),
   .done     (done)
);

// File: tb/ata_pio_timer_tb.sv
module ata_pio_timer_tb;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          arst_n = 1'b0;
   logic          srst = 1'b0;
   logic          rdy_en = 1'b0;
   logic [CW-1:0] t_setup = '0;
   logic [CW-1:0] t_active = '0;
   logic [CW-1:0] t_hold = '0;
   logic [CW-1:0] t_recover = '0;
   logic          go = 1'b0;
   logic          wr = 1'b0;
   logic          rdy_in = 1'b1;
   logic          rd_strb, wr_strb, oe, rd_latch, done;

   int n_run = 0;
   int n_fail = 0;

   // per-cycle measurements (sample index k = 1 is the first clock after the go edge)
   int rd_first, rd_cnt, wr_first, wr_cnt, oe_cnt, oe_last;
   int lat_first, lat_cnt, done_first, done_cnt, strb_after;

   always #2 clk = ~clk;

   ata_pio_timer #(.CW(CW)) u_dut (
      .clk(clk), .arst_n(arst_n), .srst(srst), .rdy_en(rdy_en),
      .t_setup(t_setup), .t_active(t_active), .t_hold(t_hold),
      .t_recover(t_recover), .go(go), .wr(wr), .rdy_in(rdy_in),
      .rd_strb(rd_strb), .wr_strb(wr_strb), .oe(oe),
      .rd_latch(rd_latch), .done(done)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // rel > 0: rdy_in held low, raised after sample rel; rel < 0: held low; rel == 0: high
   task automatic run_cycle(input bit w, input int t1, input int t2, input int t4,
                            input int te, input bit ren, input int rel, input bit regos);
      @(negedge clk);
      t_setup = t1[CW-1:0]; t_active = t2[CW-1:0];
      t_hold = t4[CW-1:0]; t_recover = te[CW-1:0];
      rdy_en = ren; wr = w; rdy_in = (rel == 0);
      go = 1'b1;
      rd_first = 0; rd_cnt = 0; wr_first = 0; wr_cnt = 0; oe_cnt = 0; oe_last = 0;
      lat_first = 0; lat_cnt = 0; done_first = 0; done_cnt = 0; strb_after = 0;
      @(negedge clk);
      for (int k = 1; k < 3000; k++) begin
         if (rd_strb) begin if (rd_first == 0) rd_first = k; rd_cnt++; end
         if (wr_strb) begin if (wr_first == 0) wr_first = k; wr_cnt++; end
         if (oe) begin oe_cnt++; oe_last = k; end
         if (rd_latch) begin if (lat_first == 0) lat_first = k; lat_cnt++; end
         if (done) begin if (done_first == 0) done_first = k; done_cnt++; end
         if (done_first != 0 && k > done_first && (rd_strb || wr_strb || oe)) strb_after++;
         if (k == 1) go = 1'b0;
         wr = ~w;
         if (rel > 0 && k == rel) rdy_in = 1'b1;
         if (regos && k == 4) go = 1'b1;
         if (regos && k == 5) go = 1'b0;
         if (done_first != 0 && k >= done_first + 12) break;
         @(negedge clk);
      end
      rdy_in = 1'b1;
   endtask

   task automatic check_cycle(input string tag, input bit w, input int t1, input int t2,
                              input int t4, input int te, input int extra);
      int strb_first = w ? wr_first : rd_first;
      int strb_cnt   = w ? wr_cnt : rd_cnt;
      int other_cnt  = w ? rd_cnt : wr_cnt;
      int exp_done   = w ? (t1 + t2 + t4 + te + 5 + extra) : (t1 + t2 + te + 4 + extra);
      chk(strb_first == t1 + 2, {tag, " R2 strobe start"}, strb_first, t1 + 2);
      chk(strb_cnt == t2 + 1 + extra, {tag, " R3 strobe width"}, strb_cnt, t2 + 1 + extra);
      chk(other_cnt == 0, {tag, " R4 wrong strobe"}, other_cnt, 0);
      if (w) begin
         chk(oe_cnt == t1 + t2 + t4 + 3 + extra && oe_last == oe_cnt,
             {tag, " R5 oe span"}, oe_cnt, t1 + t2 + t4 + 3 + extra);
         chk(lat_cnt == 0, {tag, " R6 latch on write"}, lat_cnt, 0);
      end else begin
         chk(oe_cnt == 0, {tag, " R5 oe on read"}, oe_cnt, 0);
         chk(lat_cnt == 1 && lat_first == t1 + t2 + 3 + extra,
             {tag, " R6 latch position"}, lat_first, t1 + t2 + 3 + extra);
      end
      chk(done_first == exp_done, {tag, " R7 done position"}, done_first, exp_done);
      chk(done_cnt == 1, {tag, " R7 done width"}, done_cnt, 1);
      chk(strb_after == 0, {tag, " R7 idle after done"}, strb_after, 0);
   endtask

   task automatic t_reset_state();
      @(negedge clk);
      chk(!rd_strb && !wr_strb && !oe && !rd_latch && !done, "R1 reset outputs",
          int'({rd_strb, wr_strb, oe, rd_latch, done}), 0);
   endtask

   task automatic t_mode0();
      run_cycle(1'b0, 6, 28, 2, 23, 1'b0, 0, 1'b0);
      check_cycle("mode0 read", 1'b0, 6, 28, 2, 23, 0);
      chk(done_first - 1 == 60, "R7 mode0 read total clocks", done_first - 1, 60);
      run_cycle(1'b1, 6, 28, 2, 23, 1'b0, 0, 1'b0);
      check_cycle("mode0 write", 1'b1, 6, 28, 2, 23, 0);
   endtask

   task automatic t_zero_phases();
      run_cycle(1'b0, 0, 0, 0, 0, 1'b0, 0, 1'b0);
      check_cycle("zero read", 1'b0, 0, 0, 0, 0, 0);
      run_cycle(1'b1, 0, 0, 0, 0, 1'b0, 0, 1'b0);
      check_cycle("zero write", 1'b1, 0, 0, 0, 0, 0);
      run_cycle(1'b1, 3, 1, 5, 2, 1'b0, 0, 1'b0);
      check_cycle("mixed write", 1'b1, 3, 1, 5, 2, 0);
   endtask

   task automatic t_ready_stretch();
      // R8: count ends at sample t1+t2+2; release five samples later
      run_cycle(1'b0, 2, 3, 1, 2, 1'b1, 2 + 3 + 2 + 5, 1'b0);
      check_cycle("R8 stretch read", 1'b0, 2, 3, 1, 2, 5);
      run_cycle(1'b1, 2, 3, 1, 2, 1'b1, 2 + 3 + 2 + 4, 1'b0);
      check_cycle("R8 stretch write", 1'b1, 2, 3, 1, 2, 4);
      // release before the count ends: no stretch
      run_cycle(1'b0, 2, 6, 1, 2, 1'b1, 3, 1'b0);
      check_cycle("R8 early ready", 1'b0, 2, 6, 1, 2, 0);
   endtask

   task automatic t_ready_ignored();
      run_cycle(1'b0, 2, 3, 1, 2, 1'b0, -1, 1'b0);
      check_cycle("R9 ready off read", 1'b0, 2, 3, 1, 2, 0);
      run_cycle(1'b1, 2, 3, 1, 2, 1'b0, -1, 1'b0);
      check_cycle("R9 ready off write", 1'b1, 2, 3, 1, 2, 0);
   endtask

   task automatic t_go_in_cycle();
      run_cycle(1'b1, 6, 4, 2, 3, 1'b0, 0, 1'b1);
      check_cycle("R10 extra go", 1'b1, 6, 4, 2, 3, 0);
   endtask

   task automatic t_sync_reset();
      int bad = 0;
      @(negedge clk);
      t_setup = 8'd2; t_active = 8'd10; t_hold = 8'd2; t_recover = 8'd2;
      rdy_en = 1'b0; wr = 1'b1; go = 1'b1;
      @(negedge clk);
      go = 1'b0;
      repeat (5) @(negedge clk);
      chk(wr_strb == 1'b1, "R11 strobe before reset", int'(wr_strb), 1);
      srst = 1'b1;
      @(negedge clk);
      srst = 1'b0;
      chk(!rd_strb && !wr_strb && !oe && !rd_latch && !done, "R11 outputs after reset",
          int'({rd_strb, wr_strb, oe, rd_latch, done}), 0);
      for (int k = 0; k < 30; k++) begin
         if (rd_strb || wr_strb || oe || done || rd_latch) bad++;
         @(negedge clk);
      end
      chk(bad == 0, "R11 stays idle", bad, 0);
   endtask

   initial begin
      #(4 * 150000);
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      arst_n = 1'b1;
      t_reset_state();
      t_mode0();
      t_zero_phases();
      t_ready_stretch();
      t_ready_ignored();
      t_go_in_cycle();
      t_sync_reset();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule